// File: doc/BRIEF.md
# FFT Input Block Sequencer and Run-Time Configuration Stager

This block sits in front of a block-based FFT datapath and governs how input blocks enter it. A one-cycle start pulse opens a read window of exactly N back-to-back samples, where N is the point count in force for that block. While the window is open, the sequencer supplies a sample index and a window-enable flag, and marks the final sample. A ready flag tells the upstream driver when the next start pulse will be taken.

Three run-time settings can be changed while blocks are flowing: the transform direction, a stage-scaling word, and the base-2 logarithm of the point count. Each has its own load strobe, which writes a pending copy. The pending copies become active together, only when a block is accepted, so one block never sees a mix of old and new settings. The point-count setting must also be loaded some minimum number of cycles before the start pulse that is meant to use it.

Top module: `fft_blk_ctrl`

## Requirements
- R1: An accepted start pulse opens a read window of exactly N = 2^L consecutive cycles with `smp_en` high, where L is `act_log2n` for that block. `smp_idx` counts 0, 1, ..., N-1 across the window, one step per cycle. The first window cycle is the cycle after the edge that sampled the start pulse.
- R2: A start pulse sampled while a read window is open has no effect. It produces no commit and does not lengthen or restart the window.
- R3: `blk_rdy` is low in the cycle after an accepted start and stays low through the last sample. It is high in the cycle after the last sample. A start pulse driven in a cycle where `blk_rdy` is seen high is accepted at the next edge.
- R4: `smp_last` is high for exactly one cycle per block, in the window cycle where `smp_idx` equals N-1.
- R5: `act_inverse` (1 = inverse, 0 = forward) and `act_scale` take the value captured by the most recent `dir_load` / `scale_load` strobe at or before the accepting edge. A strobe sampled at the same edge as the accepted start counts. A strobe during an open window leaves the current block's settings unchanged.
- R6: A point-count load value below 6 is taken as 6, and a value above 14 is taken as 14.
- R7: A point-count load sampled at edge S applies to a block accepted at edge E only if E - S >= 5. Otherwise that block keeps the previous active point count, and the pending value stays available for a later block.
- R8: `cfg_commit` is high for one cycle per accepted block, in the first window cycle (`smp_idx` = 0). The new settings are already visible on the `act_*` outputs in that cycle.
- R9: After reset, `blk_rdy` is high, the direction is forward, the scaling word is zero, `act_log2n` is 6, and `smp_en`, `smp_last` and `cfg_commit` are low.
- R10: Any number of idle cycles may separate blocks without affecting the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Input block start pulse |
| dir_load | input | 1 | Load strobe for the direction setting |
| dir_in | input | 1 | Direction to stage (1 = inverse) |
| scale_load | input | 1 | Load strobe for the scaling word |
| scale_in | input | SCALE_W | Stage-scaling word to stage |
| npts_load | input | 1 | Load strobe for the point-count setting |
| npts_in | input | L2_W | log2 of the point count, unsigned |
| blk_rdy | output | 1 | Ready to accept a block start |
| smp_en | output | 1 | Read window open: a sample is taken this cycle |
| smp_idx | output | IDX_W | Index of the current sample within the block |
| smp_last | output | 1 | Final sample of the block |
| cfg_commit | output | 1 | Pulse: new settings applied, first sample |
| act_inverse | output | 1 | Active direction |
| act_scale | output | SCALE_W | Active stage-scaling word |
| act_log2n | output | L2_W | Active log2 of the point count |

## Verification
Two functions of this block can land on one clock edge: loading a setting and accepting a block. The bench provokes this by asserting a direction strobe together with a start pulse, and by placing point-count loads exactly four and exactly five cycles ahead of a start. The scoreboard then judges whether the committed settings follow the stated precedence: the same-edge direction strobe counts, and the point count needs a five-cycle lead. A start pulse and a direction strobe are also injected inside an open window. The last-sample check then confirms that neither the block length nor its settings moved.

// File: rtl/fft_hsk_pkg.sv
package fft_hsk_pkg;

  localparam int LOG2_MIN = 6;
  localparam int LOG2_MAX = 14;
  localparam int L2_W     = $clog2(LOG2_MAX + 1);
  localparam int IDX_W    = LOG2_MAX;

  // Saturate a requested log2 point count into the supported range.
  function automatic logic [L2_W-1:0] clamp_log2(input logic [L2_W-1:0] raw);
    if (int'(raw) < LOG2_MIN)      return L2_W'(LOG2_MIN);
    else if (int'(raw) > LOG2_MAX) return L2_W'(LOG2_MAX);
    else                           return raw;
  endfunction

  // Index of the final sample of a block of 2^l2 points.
  function automatic logic [IDX_W-1:0] final_index(input logic [L2_W-1:0] l2);
    return IDX_W'((32'd1 << l2) - 32'd1);
  endfunction

endpackage

// File: rtl/hsk_cfg_hold.sv
module hsk_cfg_hold #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic [W-1:0] act
);

  logic [W-1:0] pend_q;
  logic [W-1:0] next_pend;

  // A strobe on the accepting edge wins over the older pending value.
  assign next_pend = load ? din : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act    <= '0;
    end else begin
      pend_q <= next_pend;
      if (take) act <= next_pend;
    end
  end

  AST_CFG_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(act)); // R5

  AST_CFG_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && load) |=> (act == $past(din))); // R5

endmodule

// File: rtl/hsk_npts_stage.sv
module hsk_npts_stage
  import fft_hsk_pkg::*;
#(
  parameter int LEAD = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [L2_W-1:0] raw,
  input  logic            take,
  output logic [L2_W-1:0] act_l2,
  output logic            lead_met
);

  localparam int AGE_W = $clog2(LEAD + 1);

  logic [L2_W-1:0]  pend_q;
  logic [AGE_W-1:0] age_q;

  // age_q holds the distance in edges from the last load to the current edge.
  assign lead_met = (age_q >= AGE_W'(LEAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= L2_W'(LOG2_MIN);
      age_q  <= AGE_W'(LEAD);
      act_l2 <= L2_W'(LOG2_MIN);
    end else begin
      if (load) begin
        pend_q <= clamp_log2(raw);
        age_q  <= AGE_W'(1);
      end else if (!lead_met) begin
        age_q  <= age_q + AGE_W'(1);
      end
      if (take && lead_met) act_l2 <= pend_q;
    end
  end

  AST_NPTS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(act_l2) >= LOG2_MIN) && (int'(act_l2) <= LOG2_MAX)); // R6

  AST_NPTS_EARLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lead_met) |=> $stable(act_l2)); // R7

  AST_NPTS_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(act_l2)); // R7

endmodule

// File: rtl/hsk_blk_seq.sv
module hsk_blk_seq
  import fft_hsk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [L2_W-1:0]  l2,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             rdy,
  output logic             commit
);

  logic [IDX_W-1:0] last_idx;

  assign last_idx = final_index(l2);
  assign accept   = start && !busy;
  assign last     = busy && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      rdy    <= 1'b1;
      commit <= 1'b0;
    end else begin
      commit <= accept;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
        rdy  <= 1'b0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          idx  <= '0;
          rdy  <= 1'b1;
        end else begin
          idx  <= idx + IDX_W'(1);
        end
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= last_idx)); // R1

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !commit); // R2

  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rdy); // R3

  AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (rdy && !busy)); // R3

  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last); // R4

  AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy && idx == '0)); // R8

endmodule

// File: rtl/fft_blk_ctrl.sv
module fft_blk_ctrl
  import fft_hsk_pkg::*;
#(
  parameter int SCALE_W = 2 * ((LOG2_MAX + 1) / 2),
  parameter int LEAD    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_start,
  input  logic               dir_load,
  input  logic               dir_in,
  input  logic               scale_load,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               npts_load,
  input  logic [L2_W-1:0]    npts_in,
  output logic               blk_rdy,
  output logic               smp_en,
  output logic [IDX_W-1:0]   smp_idx,
  output logic               smp_last,
  output logic               cfg_commit,
  output logic               act_inverse,
  output logic [SCALE_W-1:0] act_scale,
  output logic [L2_W-1:0]    act_log2n
);

  logic blk_accept;
  logic npts_lead_met;

  hsk_cfg_hold #(.W(1)) u_dir (
    .clk  (clk),
    .rst_n(rst_n),
    .load (dir_load),
    .din  (dir_in),
    .take (blk_accept),
    .act  (act_inverse)
  );

  hsk_cfg_hold #(.W(SCALE_W)) u_scale (
    .clk  (clk),
    .rst_n(rst_n),
    .load (scale_load),
    .din  (scale_in),
    .take (blk_accept),
    .act  (act_scale)
  );

  hsk_npts_stage #(.LEAD(LEAD)) u_npts (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (npts_load),
    .raw     (npts_in),
    .take    (blk_accept),
    .act_l2  (act_log2n),
    .lead_met(npts_lead_met)
  );

  hsk_blk_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (blk_start),
    .l2    (act_log2n),
    .accept(blk_accept),
    .busy  (smp_en),
    .idx   (smp_idx),
    .last  (smp_last),
    .rdy   (blk_rdy),
    .commit(cfg_commit)
  );

  AST_CFG_FROZEN_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !blk_accept) |=> ($stable(act_inverse) && $stable(act_scale) && $stable(act_log2n))); // R5

  AST_RDY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> !blk_rdy); // R3

endmodule

// File: tb/test_fft_blk_ctrl.sv
module test_fft_blk_ctrl;
  import fft_hsk_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 2 * ((LOG2_MAX + 1) / 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0, dir_load = 1'b0, dir_in = 1'b0;
  logic scale_load = 1'b0, npts_load = 1'b0;
  logic [SW-1:0] scale_in = '0;
  logic [L2_W-1:0] npts_in = '0;
  logic blk_rdy, smp_en, smp_last, cfg_commit, act_inverse;
  logic [IDX_W-1:0] smp_idx;
  logic [SW-1:0] act_scale;
  logic [L2_W-1:0] act_log2n;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_blk_ctrl i_fft_blk_ctrl (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .dir_load(dir_load), .dir_in(dir_in),
    .scale_load(scale_load), .scale_in(scale_in),
    .npts_load(npts_load), .npts_in(npts_in),
    .blk_rdy(blk_rdy), .smp_en(smp_en), .smp_idx(smp_idx), .smp_last(smp_last),
    .cfg_commit(cfg_commit), .act_inverse(act_inverse),
    .act_scale(act_scale), .act_log2n(act_log2n)
  );

  typedef struct {
    int            l2;
    logic          inv;
    logic [SW-1:0] sc;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0, n_push = 0, n_commit = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  exp_t cur;
  bit   in_blk = 0, rdy_due = 0, idx_bad = 0;
  int   cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_due) begin
        chk(blk_rdy == 1'b1, "R3", "ready after last", blk_rdy, 1);
        rdy_due = 0;
      end
      if (cfg_commit) begin
        n_commit++;
        chk(!in_blk, "R2", "commit inside open window", in_blk, 0);
        chk(q.size() > 0, "R2", "commit without accepted start", q.size(), 1);
        if (q.size() > 0) begin
          cur = q.pop_front();
          chk(int'(act_log2n) == cur.l2, cur.tag, "committed log2n", act_log2n, cur.l2);
          chk(act_inverse == cur.inv, cur.tag, "committed direction", act_inverse, cur.inv);
          chk(act_scale == cur.sc, cur.tag, "committed scale", act_scale, cur.sc);
        end
        chk(blk_rdy == 1'b0, "R3", "ready in first window cycle", blk_rdy, 0);
        chk(smp_idx == '0, "R8", "index at commit", smp_idx, 0);
        in_blk = 1; cnt = 0; idx_bad = 0;
      end
      if (smp_en) begin
        if (int'(smp_idx) != cnt) idx_bad = 1;
        if (smp_last) begin
          chk(cnt == (1 << cur.l2) - 1, "R4", "last flag position", cnt, (1 << cur.l2) - 1);
          chk(!idx_bad, "R1", "index sequence broken", idx_bad, 0);
          chk(act_inverse == cur.inv && act_scale == cur.sc && int'(act_log2n) == cur.l2,
              "R5", "settings moved during block", act_inverse, cur.inv);
          in_blk = 0; rdy_due = 1;
        end
        cnt++;
      end else if (smp_last) begin
        chk(0, "R4", "last flag outside window", 1, 0);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_rdy();
    while (!blk_rdy) tick();
  endtask

  // Start a block as soon as ready; optional same-edge direction strobe.
  task automatic start_block(input int l2, input logic inv, input logic [SW-1:0] sc,
                             input string tag, input bit dstrobe = 0, input logic dval = 0);
    exp_t e;
    wait_rdy();
    blk_start = 1'b1;
    if (dstrobe) begin dir_load = 1'b1; dir_in = dval; end
    e.l2 = l2; e.inv = inv; e.sc = sc; e.tag = tag;
    q.push_back(e); n_push++;
    tick();
    blk_start = 1'b0; dir_load = 1'b0;
    chk(cfg_commit == 1'b1, "R3", "start after ready not accepted", cfg_commit, 1);
  endtask

  // Load point count, then start exactly k edges later.
  task automatic lead_block(input logic [L2_W-1:0] raw, input int k, input int l2,
                            input logic inv, input logic [SW-1:0] sc, input string tag);
    wait_rdy();
    npts_load = 1'b1; npts_in = raw;
    tick();
    npts_load = 1'b0;
    repeat (k - 1) tick();
    start_block(l2, inv, sc, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R9 reset state
    chk(blk_rdy == 1'b1, "R9", "ready", blk_rdy, 1);
    chk(act_inverse == 1'b0, "R9", "direction", act_inverse, 0);
    chk(act_scale == '0, "R9", "scale", act_scale, 0);
    chk(int'(act_log2n) == 6, "R9", "log2n", act_log2n, 6);
    chk(!smp_en && !smp_last && !cfg_commit, "R9", "flags idle", smp_en, 0);

    // R1: default block
    start_block(6, 1'b0, '0, "R1");

    // R10 long idle gap, R5 staged settings
    wait_rdy();
    repeat (37) tick();
    dir_load = 1'b1; dir_in = 1'b1; scale_load = 1'b1; scale_in = SW'(14'h1555);
    tick();
    dir_load = 1'b0; scale_load = 1'b0;
    repeat (20) tick();
    start_block(6, 1'b1, SW'(14'h1555), "R10");

    // R5 same-edge direction strobe counts
    start_block(6, 1'b0, SW'(14'h1555), "R5", 1'b1, 1'b0);

    // R2 / R5: start pulse and strobes inside an open window
    repeat (10) tick();
    blk_start = 1'b1; dir_load = 1'b1; dir_in = 1'b1;
    scale_load = 1'b1; scale_in = SW'(14'h0a0a);
    tick();
    blk_start = 1'b0; dir_load = 1'b0; scale_load = 1'b0;
    start_block(6, 1'b1, SW'(14'h0a0a), "R5");

    // R7: four-edge lead is too short, pending value used later
    lead_block(4'd7, 4, 6, 1'b1, SW'(14'h0a0a), "R7");
    start_block(7, 1'b1, SW'(14'h0a0a), "R7");
    // R7: exactly five-edge lead applies
    lead_block(4'd8, 5, 8, 1'b1, SW'(14'h0a0a), "R7");
    // R6 clamps
    lead_block(4'd3, 6, 6, 1'b1, SW'(14'h0a0a), "R6");
    lead_block(4'd15, 5, 14, 1'b1, SW'(14'h0a0a), "R6");
    // R3 back-to-back starts at first ready cycle
    start_block(14, 1'b1, SW'(14'h0a0a), "R3");

    wait_rdy();
    repeat (3) tick();
    chk(q.size() == 0, "R2", "unconsumed expectations", q.size(), 0);
    chk(n_commit == n_push, "R2", "commit count", n_commit, n_push);
    finish_run();
  end

endmodule